// File: doc/BRIEF.md
# Always-on Seconds Clock Register Bank

This block keeps wall-clock time in seconds for a domain that stays powered while the rest of the chip sleeps. Time is held as two 32-bit quantities: a base that software loads, and a running counter that advances on a 1 Hz tick. The time the block reports is their sum, taken modulo 2^32. Two general-purpose 32-bit flag words are also kept. By convention flag word 0 holds the value 1 once the time has been set.

Software reaches the block through a 16-bit register port. It places 32-bit operands in a pair of staging registers and sets command bits in a command register. Those commands do nothing until an isolation-enable pulse arrives from a separate handshake unit. On that pulse the block clears the counter, loads the base or the flags, and fills a read-result pair, in that order. The counter is read in two stages. A capture command, run on the isolation pulse, freezes the counter into a holding register. A later write to a trigger register copies the held value into a pair of snapshot registers that software can read.

Top module: `rtc_bank`

## Requirements
- R1: After synchronous reset, the base, counter, both flag words, the hold value, the snapshot, the read result and every writable register are zero, so every mapped address reads 0 and `time_valid` is low.
- R2: Register map (byte addresses, 16-bit data): command 0x00, whose only writable bits are 1, 2, 3, 5, 6, 7 and 8 (all others read 0); capture arm 0x04 bit 0; staging low 0x10 and high 0x14; read result low 0x24 and high 0x28, which are read-only; snapshot low 0x30 and high 0x34, which are read-only; trigger 0x38, which reads 0. Any other address reads 0, and writes to it are ignored.
- R3: Setting command or capture bits changes no time state until `iso_en` is high at a clock edge.
- R4: On `iso_en`, command bit 1 loads the base from {staging high, staging low}. Bit 5 loads flag word 0 and bit 6 loads flag word 1 from the same staging value.
- R5: On `iso_en`, command bit 2 copies the base into the read result, bit 7 copies flag word 0 and bit 8 copies flag word 1. If more than one of these bits is set, the base takes priority, then flag 0, then flag 1.
- R6: On `iso_en`, command bit 3 sets the counter to zero. It leaves the base unchanged, and it overrides a tick that arrives in the same cycle.
- R7: When no counter clear is applied, each clock cycle with `tick_1hz` high adds one to the counter.
- R8: On `iso_en` with capture-arm bit 0 set, the counter is frozen into the hold register. A write to 0x38 with data bit 0 set copies the hold register into the snapshot pair. Until that write, the snapshot keeps its old value.
- R9: Commands that fire on the same pulse take effect in this order: counter clear, then writes, then reads. A read returns the value just written, and a capture on the same pulse holds 0 when a clear is also pending.
- R10: `cur_time` equals base plus counter modulo 2^32. `time_valid` is high exactly when flag word 0 equals 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle seconds tick |
| iso_en | input | 1 | Isolation-enable pulse that executes pending commands |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| cur_time | output | 32 | Base plus counter, in seconds |
| time_valid | output | 1 | Flag word 0 equals 1 |

## Verification
Two pairs of functions can fall in the same cycle. A seconds tick can land on the pulse that clears the counter, and a base write can land on the pulse that also reads the base and captures the counter. The bench provokes both by raising `tick_1hz` together with `iso_en`, and by setting clear, write, read and capture bits for a single pulse. It then checks that the counter restarts at zero, that the read result shows the freshly written base, and that the snapshot later shows 0. A behavioural reference model runs alongside the design and compares the read data, the time and the valid flag on every cycle.

// File: rtl/rtc_bank_pkg.sv
package rtc_bank_pkg;

    localparam int REG_W  = 16;
    localparam int TIME_W = 2 * REG_W;
    localparam int ADDR_W = 8;

    // Byte addresses decoded by the register port
    localparam int A_CMD   = 'h00;
    localparam int A_CAP   = 'h04;
    localparam int A_STG_L = 'h10;
    localparam int A_STG_H = 'h14;
    localparam int A_RES_L = 'h24;
    localparam int A_RES_H = 'h28;
    localparam int A_SNP_L = 'h30;
    localparam int A_SNP_H = 'h34;
    localparam int A_TRIG  = 'h38;

    // Command bit positions
    localparam int B_WR_BASE = 1;
    localparam int B_RD_BASE = 2;
    localparam int B_CLR_CNT = 3;
    localparam int B_WR_F0   = 5;
    localparam int B_WR_F1   = 6;
    localparam int B_RD_F0   = 7;
    localparam int B_RD_F1   = 8;

    localparam logic [REG_W-1:0] CMD_MASK =
        REG_W'((1 << B_WR_BASE) | (1 << B_RD_BASE) | (1 << B_CLR_CNT) |
               (1 << B_WR_F0) | (1 << B_WR_F1) | (1 << B_RD_F0) | (1 << B_RD_F1));

    typedef struct packed {
        logic       clr_cnt;
        logic       wr_base;
        logic [1:0] wr_flag;
        logic       rd_base;
        logic [1:0] rd_flag;
    } cmd_t;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_BASE,
        SRC_F0,
        SRC_F1
    } rd_src_e;

    function automatic cmd_t decode_cmd(logic [REG_W-1:0] r);
        cmd_t c;
        c.clr_cnt    = r[B_CLR_CNT];
        c.wr_base    = r[B_WR_BASE];
        c.wr_flag[0] = r[B_WR_F0];
        c.wr_flag[1] = r[B_WR_F1];
        c.rd_base    = r[B_RD_BASE];
        c.rd_flag[0] = r[B_RD_F0];
        c.rd_flag[1] = r[B_RD_F1];
        return c;
    endfunction

    function automatic rd_src_e pick_read(cmd_t c);
        if (c.rd_base)         return SRC_BASE;
        else if (c.rd_flag[0]) return SRC_F0;
        else if (c.rd_flag[1]) return SRC_F1;
        else                   return SRC_NONE;
    endfunction

endpackage

// File: rtl/rtc_bank_regs.sv
module rtc_bank_regs
    import rtc_bank_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = REG_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    output logic [DW-1:0]   cmd_raw,
    output logic            cap_arm,
    output logic [2*DW-1:0] stage_word,
    output logic            snap_req
);

    logic [DW-1:0] stg_lo_q, stg_hi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_raw  <= '0;
            cap_arm  <= 1'b0;
            stg_lo_q <= '0;
            stg_hi_q <= '0;
        end else if (we) begin
            case (int'(addr))
                A_CMD:   cmd_raw  <= wdata & CMD_MASK;
                A_CAP:   cap_arm  <= wdata[0];
                A_STG_L: stg_lo_q <= wdata;
                A_STG_H: stg_hi_q <= wdata;
                default: ;
            endcase
        end
    end

    assign stage_word = {stg_hi_q, stg_lo_q};
    assign snap_req   = we && (int'(addr) == A_TRIG) && wdata[0];

endmodule

// File: rtl/rtc_bank_core.sv
module rtc_bank_core
    import rtc_bank_pkg::*;
#(
    parameter int TW     = TIME_W,
    parameter int NFLAGS = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      tick,
    input  logic                      iso,
    input  cmd_t                      cmd,
    input  logic                      cap_arm,
    input  logic [TW-1:0]             stage_word,
    input  logic                      snap_req,
    output logic [TW-1:0]             base_q,
    output logic [TW-1:0]             cnt_q,
    output logic [NFLAGS-1:0][TW-1:0] flag_q,
    output logic [TW-1:0]             hold_q,
    output logic [TW-1:0]             snap_q,
    output logic [TW-1:0]             res_q
);

    logic                      do_clr;
    logic [TW-1:0]             cnt_cleared;
    logic [TW-1:0]             base_nxt;
    logic [NFLAGS-1:0][TW-1:0] flag_nxt;

    // Stage 1 of a pulse: counter clear
    assign do_clr      = iso && cmd.clr_cnt;
    assign cnt_cleared = do_clr ? '0 : cnt_q;

    // Stage 2: writes from the staging word
    assign base_nxt = (iso && cmd.wr_base) ? stage_word : base_q;

    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        assign flag_nxt[g] = (iso && cmd.wr_flag[g]) ? stage_word : flag_q[g];

        always_ff @(posedge clk) begin
            if (rst) flag_q[g] <= '0;
            else     flag_q[g] <= flag_nxt[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            base_q <= '0;
            hold_q <= '0;
            snap_q <= '0;
            res_q  <= '0;
        end else begin
            if (do_clr)    cnt_q <= '0;
            else if (tick) cnt_q <= cnt_q + TW'(1);

            base_q <= base_nxt;

            if (iso && cap_arm) hold_q <= cnt_cleared;
            if (snap_req)       snap_q <= hold_q;

            // Stage 3: reads see post-write state
            if (iso) begin
                case (pick_read(cmd))
                    SRC_BASE: res_q <= base_nxt;
                    SRC_F0:   res_q <= flag_nxt[0];
                    SRC_F1:   res_q <= flag_nxt[1];
                    default:  ;
                endcase
            end
        end
    end

endmodule

// File: rtl/rtc_bank.sv
module rtc_bank
    import rtc_bank_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = REG_W,
    parameter int TW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_1hz,
    input  logic          iso_en,
    input  logic          reg_we,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic [TW-1:0] cur_time,
    output logic          time_valid
);

    logic [DW-1:0]        cmd_raw;
    cmd_t                 cmd;
    logic                 cap_arm;
    logic [TW-1:0]        stage_word;
    logic                 snap_req;
    logic [TW-1:0]        base_q, cnt_q, hold_q, snap_q, res_q;
    logic [1:0][TW-1:0]   flag_q;

    rtc_bank_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .cmd_raw    (cmd_raw),
        .cap_arm    (cap_arm),
        .stage_word (stage_word),
        .snap_req   (snap_req)
    );

    assign cmd = decode_cmd(cmd_raw);

    rtc_bank_core #(.TW(TW), .NFLAGS(2)) u_core (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick_1hz),
        .iso        (iso_en),
        .cmd        (cmd),
        .cap_arm    (cap_arm),
        .stage_word (stage_word),
        .snap_req   (snap_req),
        .base_q     (base_q),
        .cnt_q      (cnt_q),
        .flag_q     (flag_q),
        .hold_q     (hold_q),
        .snap_q     (snap_q),
        .res_q      (res_q)
    );

    always_comb begin
        case (int'(reg_addr))
            A_CMD:   reg_rdata = cmd_raw;
            A_CAP:   reg_rdata = {{(DW-1){1'b0}}, cap_arm};
            A_STG_L: reg_rdata = stage_word[DW-1:0];
            A_STG_H: reg_rdata = stage_word[TW-1:DW];
            A_RES_L: reg_rdata = res_q[DW-1:0];
            A_RES_H: reg_rdata = res_q[TW-1:DW];
            A_SNP_L: reg_rdata = snap_q[DW-1:0];
            A_SNP_H: reg_rdata = snap_q[TW-1:DW];
            default: reg_rdata = '0;
        endcase
    end

    assign cur_time   = base_q + cnt_q;
    assign time_valid = (flag_q[0] == TW'(1));

endmodule

// File: rtl/rtc_bank_chk.sv
module rtc_bank_chk
    import rtc_bank_pkg::*;
#(
    parameter int TW = TIME_W
) (
    input logic          clk,
    input logic          rst,
    input logic          iso_en,
    input logic          tick_1hz,
    input cmd_t          cmd,
    input logic          cap_arm,
    input logic          snap_req,
    input logic [TW-1:0] stage_word,
    input logic [TW-1:0] base_q,
    input logic [TW-1:0] cnt_q,
    input logic [TW-1:0] flag0_q,
    input logic [TW-1:0] hold_q,
    input logic [TW-1:0] snap_q
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (base_q == '0 && cnt_q == '0 && hold_q == '0 && snap_q == '0 && flag0_q == '0));

    assert_deferred_R3: assert property (@(posedge clk) disable iff (rst)
        !iso_en |=> ($stable(base_q) && $stable(flag0_q) && $stable(hold_q)));

    assert_base_load_R4: assert property (@(posedge clk) disable iff (rst)
        (iso_en && cmd.wr_base) |=> base_q == $past(stage_word));

    assert_clear_cnt_R6: assert property (@(posedge clk) disable iff (rst)
        (iso_en && cmd.clr_cnt) |=> cnt_q == '0);

    assert_tick_step_R7: assert property (@(posedge clk) disable iff (rst)
        (!iso_en && tick_1hz) |=> cnt_q == $past(cnt_q) + TW'(1));

    assert_snap_copy_R8: assert property (@(posedge clk) disable iff (rst)
        snap_req |=> snap_q == $past(hold_q));

    assert_clear_before_capture_R9: assert property (@(posedge clk) disable iff (rst)
        (iso_en && cmd.clr_cnt && cap_arm) |=> hold_q == '0);

endmodule

bind rtc_bank rtc_bank_chk #(.TW(TW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .iso_en     (iso_en),
    .tick_1hz   (tick_1hz),
    .cmd        (cmd),
    .cap_arm    (cap_arm),
    .snap_req   (snap_req),
    .stage_word (stage_word),
    .base_q     (base_q),
    .cnt_q      (cnt_q),
    .flag0_q    (flag_q[0]),
    .hold_q     (hold_q),
    .snap_q     (snap_q)
);

// File: tb/rtc_bank_tb.sv
module rtc_bank_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick_1hz = 1'b0;
    logic        iso_en = 1'b0;
    logic        reg_we = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [15:0] reg_wdata = 16'h0000;
    logic [15:0] reg_rdata;
    logic [31:0] cur_time;
    logic        time_valid;

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;
    string phase = "R1";

    always #2.5 clk = ~clk;

    rtc_bank u_dut (
        .clk        (clk),
        .rst        (rst),
        .tick_1hz   (tick_1hz),
        .iso_en     (iso_en),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .cur_time   (cur_time),
        .time_valid (time_valid)
    );

    // Behavioural reference model
    logic [31:0] m_base, m_cnt, m_f0, m_f1, m_hold, m_snap, m_res;
    logic [15:0] m_cmd, m_slo, m_shi;
    logic        m_cap;

    function automatic logic [15:0] model_read(logic [7:0] a);
        case (a)
            8'h00: return m_cmd;
            8'h04: return {15'd0, m_cap};
            8'h10: return m_slo;
            8'h14: return m_shi;
            8'h24: return m_res[15:0];
            8'h28: return m_res[31:16];
            8'h30: return m_snap[15:0];
            8'h34: return m_snap[31:16];
            default: return 16'h0000;
        endcase
    endfunction

    always @(posedge clk) begin
        logic [31:0] stg, cnt_c;
        if (rst) begin
            m_base = 0; m_cnt = 0; m_f0 = 0; m_f1 = 0; m_hold = 0;
            m_snap = 0; m_res = 0; m_cmd = 0; m_slo = 0; m_shi = 0; m_cap = 0;
        end else begin
            stg = {m_shi, m_slo};
            if (reg_we && reg_addr == 8'h38 && reg_wdata[0]) m_snap = m_hold;
            if (iso_en) begin
                cnt_c = m_cmd[3] ? 32'd0 : m_cnt;
                if (m_cap) m_hold = cnt_c;
                if (m_cmd[3]) m_cnt = 32'd0;
                else if (tick_1hz) m_cnt = m_cnt + 1;
                if (m_cmd[1]) m_base = stg;
                if (m_cmd[5]) m_f0 = stg;
                if (m_cmd[6]) m_f1 = stg;
                if (m_cmd[2])      m_res = m_base;
                else if (m_cmd[7]) m_res = m_f0;
                else if (m_cmd[8]) m_res = m_f1;
            end else if (tick_1hz) begin
                m_cnt = m_cnt + 1;
            end
            if (reg_we) begin
                case (reg_addr)
                    8'h00: m_cmd = reg_wdata & 16'h01EE;
                    8'h04: m_cap = reg_wdata[0];
                    8'h10: m_slo = reg_wdata;
                    8'h14: m_shi = reg_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        #1;
        if (!rst && !done) begin
            check(phase, "rdata", {16'd0, reg_rdata}, {16'd0, model_read(reg_addr)});
            check(phase, "cur_time", cur_time, m_base + m_cnt);
            check(phase, "time_valid", {31'd0, time_valid}, {31'd0, (m_f0 == 32'd1)});
        end
    end

    task automatic bus_wr(logic [7:0] a, logic [15:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(bit do_iso, bit do_tick);
        @(negedge clk);
        iso_en = do_iso; tick_1hz = do_tick;
        @(negedge clk);
        iso_en = 1'b0; tick_1hz = 1'b0;
    endtask

    task automatic peek(logic [7:0] a, output logic [15:0] v);
        @(negedge clk);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic stage(logic [31:0] w);
        bus_wr(8'h10, w[15:0]);
        bus_wr(8'h14, w[31:16]);
    endtask

    task automatic peek32(logic [7:0] a, output logic [31:0] v);
        logic [15:0] lo, hi;
        peek(a, lo);
        peek(a + 8'h04, hi);
        v = {hi, lo};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v16;
        logic [31:0] v32;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        phase = "R1";
        foreach (u_addrs[i]) begin
            peek(u_addrs[i], v16);
            check("R1", "reset read", {16'd0, v16}, 32'd0);
        end
        check("R1", "reset time", cur_time, 32'd0);
        check("R1", "reset valid", {31'd0, time_valid}, 32'd0);

        // R2: register map
        phase = "R2";
        bus_wr(8'h00, 16'hFFFF);
        peek(8'h00, v16); check("R2", "cmd mask", {16'd0, v16}, 32'h01EE);
        bus_wr(8'h00, 16'h0000);
        bus_wr(8'h04, 16'hFFFF);
        peek(8'h04, v16); check("R2", "cap arm", {16'd0, v16}, 32'h0001);
        bus_wr(8'h04, 16'h0000);
        bus_wr(8'h24, 16'hBEEF);
        peek(8'h24, v16); check("R2", "result read-only", {16'd0, v16}, 32'd0);
        bus_wr(8'h08, 16'h1111);
        peek(8'h08, v16); check("R2", "unmapped", {16'd0, v16}, 32'd0);
        peek(8'h38, v16); check("R2", "trigger reads 0", {16'd0, v16}, 32'd0);

        // R3 / R4: deferred base write
        phase = "R3";
        stage(32'h1234_5678);
        peek32(8'h10, v32); check("R2", "staging", v32, 32'h1234_5678);
        bus_wr(8'h00, 16'h0002);
        repeat (4) @(negedge clk);
        check("R3", "no effect before iso", cur_time, 32'd0);
        phase = "R4";
        pulse(1, 0);
        check("R4", "base loaded", cur_time, 32'h1234_5678);

        // R7: ticks
        phase = "R7";
        repeat (3) pulse(0, 1);
        check("R7", "three ticks", cur_time, 32'h1234_567B);

        // R5: read base
        phase = "R5";
        bus_wr(8'h00, 16'h0004);
        pulse(1, 0);
        peek32(8'h24, v32); check("R5", "read base", v32, 32'h1234_5678);

        // R10: valid flag
        phase = "R10";
        stage(32'h0000_0001);
        bus_wr(8'h00, 16'h0020);
        pulse(1, 0);
        check("R10", "flag0 = 1 valid", {31'd0, time_valid}, 32'd1);
        stage(32'h0000_0002);
        pulse(1, 0);
        check("R10", "flag0 = 2 invalid", {31'd0, time_valid}, 32'd0);
        stage(32'h0000_0001);
        pulse(1, 0);
        check("R10", "flag0 back to 1", {31'd0, time_valid}, 32'd1);

        // R6: clear coinciding with a tick
        phase = "R6";
        bus_wr(8'h00, 16'h0008);
        pulse(1, 1);
        check("R6", "clear beats tick, base kept", cur_time, 32'h1234_5678);

        // R8: two-stage snapshot
        phase = "R8";
        bus_wr(8'h00, 16'h0000);
        repeat (2) pulse(0, 1);
        bus_wr(8'h04, 16'h0001);
        pulse(1, 0);
        repeat (3) pulse(0, 1);
        peek32(8'h30, v32); check("R8", "snapshot before trigger", v32, 32'd0);
        bus_wr(8'h38, 16'h0001);
        peek32(8'h30, v32); check("R8", "snapshot after trigger", v32, 32'd2);
        check("R8", "counter kept running", cur_time, 32'h1234_567D);

        // R9: clear + write + read + capture on one pulse
        phase = "R9";
        stage(32'hABCD_0100);
        bus_wr(8'h00, 16'h000E);
        pulse(1, 1);
        peek32(8'h24, v32); check("R9", "read sees new base", v32, 32'hABCD_0100);
        check("R9", "time after combined pulse", cur_time, 32'hABCD_0100);
        bus_wr(8'h38, 16'h0001);
        peek32(8'h30, v32); check("R9", "capture after clear", v32, 32'd0);
        bus_wr(8'h04, 16'h0000);

        // R5: read priority between flags
        phase = "R5";
        stage(32'h0000_0007);
        bus_wr(8'h00, 16'h0040);
        pulse(1, 0);
        bus_wr(8'h00, 16'h0180);
        pulse(1, 0);
        peek32(8'h24, v32); check("R5", "flag0 over flag1", v32, 32'd1);
        bus_wr(8'h00, 16'h0100);
        pulse(1, 0);
        peek32(8'h24, v32); check("R5", "flag1 read", v32, 32'd7);

        // R10: sum wraps modulo 2^32
        phase = "R10";
        stage(32'hFFFF_FFF0);
        bus_wr(8'h00, 16'h000A);
        pulse(1, 0);
        bus_wr(8'h00, 16'h0000);
        repeat (32) pulse(0, 1);
        check("R10", "sum wraps", cur_time, 32'h0000_0010);

        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    logic [7:0] u_addrs [9] = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h24, 8'h28, 8'h30, 8'h34, 8'h38};

endmodule